// File: doc/BRIEF.md
# Scatter-Gather Circular Trace Writer

The block accepts a stream of 32-bit trace words and writes them into 4 KiB memory pages that need not be adjacent. The page locations come from descriptor tables that sit in memory. A table can end in a link to another table, so the tables form a chain. The block fetches descriptors over a word-addressed read port with one request outstanding at a time. It stores trace words over a word-addressed write port. It also fetches the descriptor for the following page while the current page is still filling.

The buffer is circular. Once the final page of the list is full, writing goes back to the first page named by the first descriptor of the first table, and a sticky full flag is raised. Software supplies a 40-bit table base as a 32-bit low word and an 8-bit high word. It reads the 40-bit write pointer back in the same split form. Raising the enable always starts the walk from the first descriptor at the base. Lowering it freezes the block in place. A malformed descriptor sets an error flag and stops all writing.

Top module: `sg_trace_writer`

## Requirements
- R1: A descriptor is 32 bits. Bits [31:4] give physical address bits [39:12] of the page or table it points to. Bits [3:2] must be zero. Bits [1:0] give the entry type.
- R2: Words accepted on the input (in_valid and in_ready both high at a clock edge) go to consecutive word addresses inside the current page, starting at its first word. A page holds PAGE_WORDS words.
- R3: Entry type 2'b10 names an ordinary data page. After it, the next descriptor is read from the following slot of the same table.
- R4: Entry type 2'b11 is a link. The next descriptor is read from slot 0 of the table it points to. A link holds no data page.
- R5: Entry type 2'b01 names the final data page. When the last word of that page is written, writing continues at the first page, found again from slot 0 of the table at the base, and full goes high.
- R6: full stays high while writing continues, until the next rising edge of en.
- R7: The table base is {base_hi[7:0], base_lo[31:0]}, a 40-bit byte address with bits [11:0] zero. After en rises, the first descriptor read is at that address.
- R8: wp_hi and wp_lo together form {wp_hi, wp_lo}, the 40-bit byte address of the next word to be written. Once the next page has been loaded, it points at that page's first word.
- R9: in_ready is low whenever no page is loaded, for example right after enable while the first descriptor fetch is still pending.
- R10: A descriptor of type 2'b00, or with bits [3:2] nonzero, sets err. After that in_ready stays low and no word is written until the next rising edge of en.
- R11: While en is low, in_ready is low and the write pointer holds. A rising edge of en clears full and err, and writing restarts at word 0 of the first page.
- R12: At most one descriptor read is outstanding. rd_req is not raised again until rd_valid has returned the previous descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; a rising edge restarts the walk |
| base_lo | input | 32 | Table base byte address bits [31:0] |
| base_hi | input | 8 | Table base byte address bits [39:32] |
| in_valid | input | 1 | Trace word present |
| in_ready | output | 1 | Trace word can be accepted |
| in_data | input | 32 | Trace word |
| rd_req | output | 1 | Descriptor read request, one-cycle pulse |
| rd_addr | output | 38 | Descriptor word address |
| rd_valid | input | 1 | Descriptor read data valid |
| rd_data | input | 32 | Descriptor read data |
| wr_en | output | 1 | Trace data write strobe |
| wr_addr | output | 38 | Trace data word address |
| wr_data | output | 32 | Trace data |
| wp_lo | output | 32 | Next write byte address bits [31:0] |
| wp_hi | output | 8 | Next write byte address bits [39:32] |
| full | output | 1 | Sticky wrap flag |
| err | output | 1 | Malformed descriptor seen |

## Verification
The main stimulus is a three-page list: an ordinary page, a link to a second table, then an ordinary page and the final page. Trace words arrive with random gaps, and descriptor reads return with random latency. These runs show whether link slots are skipped and whether the walk goes back to the base after the final page, and they expose prefetch races between page completion and descriptor arrival. Directed cases cover the stall right after enable, full staying low until the very last word of the final page, the pointer freezing while disabled, the restart from the first page, and two forms of malformed descriptor, each of which must block every write.

// File: rtl/sg_trace_writer.sv
module sg_trace_writer #(
  parameter int PAGE_WORDS = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [31:0] base_lo,
  input  logic [7:0]  base_hi,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        rd_req,
  output logic [37:0] rd_addr,
  input  logic        rd_valid,
  input  logic [31:0] rd_data,
  output logic        wr_en,
  output logic [37:0] wr_addr,
  output logic [31:0] wr_data,
  output logic [31:0] wp_lo,
  output logic [7:0]  wp_hi,
  output logic        full,
  output logic        err
);

  localparam int IW = $clog2(PAGE_WORDS);
  localparam logic [IW-1:0] LAST_W = IW'(PAGE_WORDS - 1);

  logic          en_q, pend, drop;
  logic          cur_v, cur_last, nxt_v, nxt_last;
  logic          full_q, err_q;
  logic [27:0]   base_pg, cur_pg, nxt_pg;
  logic [37:0]   dptr;
  logic [IW-1:0] widx;
  logic [39:0]   wp;

  wire       start    = en && !en_q;
  wire [1:0] dtype    = rd_data[1:0];
  wire       d_bad    = (rd_data[3:2] != 2'b00) || (dtype == 2'b00);
  wire       d_link   = (dtype == 2'b11);
  wire       d_last   = (dtype == 2'b01);
  wire       resp     = rd_valid && pend && !drop && !start;
  wire       got_pg   = resp && !d_bad && !d_link;
  wire       acc      = in_valid && in_ready;
  wire       pg_end   = (widx == LAST_W);
  wire       cur_done = acc && pg_end;

  assign in_ready = en && en_q && !err_q && cur_v;
  assign rd_req   = en && en_q && !err_q && !pend && !nxt_v;
  assign rd_addr  = dptr;
  assign wr_en    = acc;
  assign wr_addr  = {cur_pg, 10'b0} | 38'(widx);
  assign wr_data  = in_data;
  assign wp_lo    = wp[31:0];
  assign wp_hi    = wp[39:32];
  assign full     = full_q;
  assign err      = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; pend <= 1'b0; drop <= 1'b0;
      cur_v <= 1'b0; cur_last <= 1'b0; nxt_v <= 1'b0; nxt_last <= 1'b0;
      full_q <= 1'b0; err_q <= 1'b0;
      base_pg <= '0; cur_pg <= '0; nxt_pg <= '0;
      dptr <= '0; widx <= '0; wp <= '0;
    end else begin
      en_q <= en;
      if (start) begin
        base_pg <= {base_hi, base_lo[31:12]};
        dptr    <= {base_hi, base_lo[31:12], 10'b0};
        pend    <= pend && !rd_valid;
        drop    <= pend && !rd_valid;
        cur_v   <= 1'b0;
        nxt_v   <= 1'b0;
        widx    <= '0;
        full_q  <= 1'b0;
        err_q   <= 1'b0;
      end else begin
        if (rd_req) pend <= 1'b1;
        if (rd_valid && pend) begin
          pend <= 1'b0;
          drop <= 1'b0;
        end
        if (resp) begin
          if (d_bad) err_q <= 1'b1;
          else if (d_link) dptr <= {rd_data[31:4], 10'b0};
          else dptr <= d_last ? {base_pg, 10'b0} : dptr + 38'd1;
        end
        if (acc) begin
          widx <= pg_end ? '0 : widx + 1'b1;
          wp   <= wp + 40'd4;
          if (pg_end && cur_last) full_q <= 1'b1;
        end
        if (cur_done) begin
          if (nxt_v) begin
            cur_pg   <= nxt_pg;
            cur_last <= nxt_last;
            nxt_v    <= 1'b0;
            wp       <= {nxt_pg, 12'b0};
          end else if (got_pg) begin
            cur_pg   <= rd_data[31:4];
            cur_last <= d_last;
            wp       <= {rd_data[31:4], 12'b0};
          end else begin
            cur_v <= 1'b0;
          end
        end else if (got_pg) begin
          if (!cur_v) begin
            cur_pg   <= rd_data[31:4];
            cur_last <= d_last;
            cur_v    <= 1'b1;
            widx     <= '0;
            wp       <= {rd_data[31:4], 12'b0};
          end else begin
            nxt_pg   <= rd_data[31:4];
            nxt_last <= d_last;
            nxt_v    <= 1'b1;
          end
        end
      end
    end
  end

  assert_base_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (base_lo[11:0] == 12'h000));

  assert_single_fetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  assert_wp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !pg_end) |=> (wp == $past(wp) + 40'd4));

  assert_full_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(wr_en));

  assert_err_on_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(rd_valid));

  assert_restart_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> (!full_q && !err_q));

endmodule

// File: tb/sg_trace_writer_tb.sv
module sg_trace_writer_tb;
  localparam int PW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] base_lo = '0;
  logic [7:0]  base_hi = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, rd_req, wr_en, full, err;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [37:0] rd_addr, wr_addr;
  logic [31:0] wr_data, wp_lo;
  logic [7:0]  wp_hi;

  sg_trace_writer #(.PAGE_WORDS(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .base_lo(base_lo), .base_hi(base_hi),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wp_lo(wp_lo), .wp_hi(wp_hi), .full(full), .err(err));

  always #10 clk = ~clk;

  localparam logic [27:0] T1 = 28'h1234567, T2 = 28'h0ABCDEF;
  localparam logic [27:0] T3 = 28'h0000777, T4 = 28'h0000888;
  localparam logic [27:0] PA = 28'hA000011, PB = 28'h3C00222, PC = 28'hFFFF333;
  localparam logic [27:0] PD = 28'h5550444;

  int n_cmp = 0, n_bad = 0;
  int nwr = 0, bad_rd = 0, cycles = 0;
  logic [31:0] dmem [logic [37:0]];
  logic [27:0] exp_pg [3] = '{PA, PB, PC};
  int pidx = 0, widx = 0;
  bit exp_full = 0, outst = 0, want_rd = 0, want_wr = 0;
  logic [37:0] first_rd = '0, first_wr = '0;
  logic [37:0] pa = '0;
  int cd = 0;

  task automatic check(input bit ok, input string msg, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
    end
  endtask

  function automatic logic [31:0] desc(input logic [27:0] pg, input logic [1:0] t);
    return {pg, 2'b00, t};
  endfunction

  function automatic logic [39:0] exp_wp();
    return {exp_pg[pidx], 12'b0} + 40'(widx * 4);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data <= '0;
      cd <= 0;
    end else begin
      rd_valid <= 1'b0;
      if (rd_req) begin
        pa <= rd_addr;
        cd <= 1 + int'($urandom % 3);
      end else if (cd != 0) begin
        cd <= cd - 1;
        if (cd == 1) begin
          rd_valid <= 1'b1;
          rd_data <= dmem.exists(pa) ? dmem[pa] : 32'h0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      if (wr_en) begin
        nwr++;
        if (want_wr) begin first_wr = wr_addr; want_wr = 0; end
        check(wr_addr == ({exp_pg[pidx], 10'b0} | 38'(widx)),
              "R1 R2 R3 R4 R5 write address", wr_addr, {exp_pg[pidx], 10'b0} | 38'(widx));
        widx++;
        if (widx == PW) begin
          widx = 0;
          if (pidx == 2) begin pidx = 0; exp_full = 1; end
          else pidx++;
        end
      end
      if (rd_req) begin
        if (outst) bad_rd++;
        outst = 1;
        if (want_rd) begin first_rd = rd_addr; want_rd = 0; end
      end
      if (rd_valid) outst = 0;
    end
  end

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      repeat ($urandom % 3) @(negedge clk);
      in_valid = 1'b1;
      in_data = $urandom;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic restart(input logic [27:0] tbl);
    @(negedge clk);
    en = 1'b0;
    repeat (6) @(negedge clk);
    base_lo = {tbl[19:0], 12'h000};
    base_hi = tbl[27:20];
    pidx = 0; widx = 0; exp_full = 0;
    want_wr = 1;
    en = 1'b1;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 100000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [39:0] wsave;
    int nsave;
    void'($urandom(32'h5EED1234));
    dmem[{T1, 10'd0}] = desc(PA, 2'b10);
    dmem[{T1, 10'd1}] = desc(T2, 2'b11);
    dmem[{T2, 10'd0}] = desc(PB, 2'b10);
    dmem[{T2, 10'd1}] = desc(PC, 2'b01);
    dmem[{T3, 10'd0}] = desc(PD, 2'b10);
    dmem[{T3, 10'd1}] = {PD, 2'b01, 2'b10};
    dmem[{T4, 10'd0}] = {PA, 2'b00, 2'b00};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 0, "R11 reset in_ready", in_ready, 0);
    check(full == 0, "R6 reset full", full, 0);
    check(err == 0, "R10 reset err", err, 0);
    check({wp_hi, wp_lo} == 0, "R8 reset wp", {wp_hi, wp_lo}, 0);
    check(rd_req == 0, "R12 reset rd_req", rd_req, 0);

    base_lo = {T1[19:0], 12'h000};
    base_hi = T1[27:20];
    want_rd = 1;
    want_wr = 1;
    en = 1'b1;
    @(negedge clk);
    check(in_ready == 0, "R9 stall before first page", in_ready, 0);

    push(3 * PW - 1);
    check(first_rd == {T1, 10'd0}, "R7 first descriptor address", first_rd, {T1, 10'd0});
    check(full == 0, "R5 full before final word", full, 0);
    push(1);
    check(full == 1, "R5 full after final page", full, 1);
    push(20);
    check(full == 1, "R6 full sticky", full, 1);
    check(exp_full == 1, "R5 wrapped to first page", exp_full, 1);

    repeat (10) @(negedge clk);
    check(wp_lo == exp_wp()[31:0], "R8 wp_lo", wp_lo, exp_wp()[31:0]);
    check(wp_hi == exp_wp()[39:32], "R8 wp_hi", wp_hi, exp_wp()[39:32]);

    en = 1'b0;
    @(negedge clk);
    wsave = {wp_hi, wp_lo};
    nsave = nwr;
    in_valid = 1'b1;
    repeat (10) begin
      @(negedge clk);
      check(in_ready == 0, "R11 ready low while disabled", in_ready, 0);
    end
    in_valid = 1'b0;
    check(nwr == nsave, "R11 no writes while disabled", nwr, nsave);
    check({wp_hi, wp_lo} == wsave, "R11 wp held while disabled", {wp_hi, wp_lo}, wsave);

    restart(T1);
    @(negedge clk);
    check(full == 0, "R11 full cleared on enable", full, 0);
    push(40);
    check(first_wr == {PA, 10'd0}, "R11 restart at first page", first_wr, {PA, 10'd0});
    push(200);
    check(full == 1, "R6 full after long random run", full, 1);
    repeat (10) @(negedge clk);
    check({wp_hi, wp_lo} == exp_wp(), "R8 R3 wp after random run", {wp_hi, wp_lo}, exp_wp());

    restart(T3);
    repeat (20) @(negedge clk);
    check(err == 1, "R10 reserved bits set err", err, 1);
    check(in_ready == 0, "R10 ready low on err", in_ready, 0);
    nsave = nwr;
    in_valid = 1'b1;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    check(nwr == nsave, "R10 no writes after err", nwr, nsave);

    restart(T4);
    repeat (20) @(negedge clk);
    check(err == 1, "R10 type 00 sets err", err, 1);

    restart(T1);
    @(negedge clk);
    check(err == 0, "R11 err cleared on enable", err, 0);
    push(PW + 3);
    check(first_wr == {PA, 10'd0}, "R11 restart after err", first_wr, {PA, 10'd0});
    check(bad_rd == 0, "R12 single outstanding read", bad_rd, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule